// File: doc/BRIEF.md
# Framed Serial Transmitter with Underrun Policy

This block is the transmit half of a framed serial port. A frame holds a fixed number of words, each a fixed number of bits, sent most significant bit first on `sdo`, one bit per `bit_en` strobe. In host mode the block starts a frame itself: it raises `fs_out` for one bit time and then shifts. In client mode a frame starts on the strobe where `fs_in` is sampled high. Words come from a single-entry holding buffer, written over a small register bus. The same bus gives access to a status register and an error flag register.

The block has a fixed policy for the case where a word is due and the buffer is empty. It raises a sticky underrun bit and sends zeros until the frame ends. In host mode it waits for the error to be cleared before it starts another frame. Clearing the error flushes the buffer and blocks further writes until software reads the status register and sees the error bit at zero. A control input, `ign_tur`, relaxes this policy: the buffer is checked again at every frame boundary. In client mode, a frame sync that arrives in the middle of a frame is reported as a length error, and the frame carries on unchanged.

Top module: `ftx_underrun_ctrl`

## Requirements
- R1: After reset, `sdo`, `fs_out` and `err_irq` are 0, and the status register (address 1) reads 0.
- R2: In host mode, when the buffer holds data and no blocking underrun is pending, `fs_out` is high for exactly one bit time. The following FRAME_WORDS×FLEN bit times carry the buffered words MSB first, and a new buffer entry is taken for each word.
- R3: When a word must be loaded and the buffer is empty, status bit 0 (underrun) is set and `sdo` is 0 for the rest of that frame.
- R4: An underrun or length error sets bit 0 of the flag register (address 2), seen on `err_irq`, only while `err_ie` is 1. The status bits are set whatever the value of `err_ie`.
- R5: In host mode with `ign_tur` = 0, no frame sync is produced while the underrun bit is set, even if the buffer has been written.
- R6: Writing 1 to status bit 0 while it is set clears it and discards any buffered word.
- R7: After that clear, writes to the data register (address 0) are discarded until a read of the status register returns bit 0 as 0. Later writes are accepted.
- R8: In client mode, a frame sync that finds the buffer empty sets the underrun bit and produces an all-zero frame.
- R9: In client mode with `ign_tur` = 0, a frame sync that arrives while the underrun bit is set produces zeros, even when the buffer holds data. That data is kept.
- R10: In client mode with `ign_tur` = 1, a frame sync checks the buffer again and sends its contents despite a set underrun bit.
- R11: In host mode with `ign_tur` = 1, a word written during an underrun frame is not sent in that frame. It starts a new frame as soon as the underrun frame ends.
- R12: In client mode, a frame sync sampled before the current frame's last bit sets status bit 1 (length error) and leaves the frame's data unchanged.
- R13: Status and flag bits are cleared by writing 1 to their position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | One-cycle strobe per serial bit time |
| host_mode | input | 1 | 1: block drives frame sync; 0: block follows `fs_in` |
| ign_tur | input | 1 | 1: recheck the buffer at each frame boundary despite underrun |
| err_ie | input | 1 | Enables setting of the error flag |
| fs_in | input | 1 | Frame sync input, client mode, sampled on `bit_en` |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address: 0 data, 1 status, 2 flag |
| bus_wdata | input | FLEN | Register write data |
| bus_rdata | output | FLEN | Register read data for `bus_addr` |
| fs_out | output | 1 | Frame sync pulse, host mode |
| sdo | output | 1 | Serial data out |
| err_irq | output | 1 | Error interrupt flag |

## Verification
The assertions assume that `host_mode` and `ign_tur` stay fixed while a frame is in progress. They also assume that `bus_wr` and `bus_rd` are never high together and carry only the addresses 0 to 2. The bench changes the mode inputs only between frames, when the framer is idle. It drives every bus strobe for exactly one cycle. It holds `bit_en` high, so that every cycle is one bit time and the cycle counts line up with the frame.

// File: rtl/ftx_pkg.sv
`timescale 1ns/1ps
// Shared types for the framed transmitter.
// Assumes: a 2-bit register address bus.
package ftx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SYNC  = 2'd1,
        ST_SHIFT = 2'd2
    } ftx_state_e;

    localparam logic [1:0] REG_DATA = 2'd0;
    localparam logic [1:0] REG_STAT = 2'd1;
    localparam logic [1:0] REG_FLAG = 2'd2;
endpackage

// File: rtl/ftx_bufregs.sv
`timescale 1ns/1ps
// Holding buffer, status bits, error flag and the write lockout.
// Assumes: DW >= 2; consume pulses only when buf_valid is high.
module ftx_bufregs #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          err_ie,
    input  logic          consume,
    input  logic          tur_evt,
    input  logic          len_evt,
    output logic          buf_valid,
    output logic [DW-1:0] buf_data,
    output logic          tur,
    output logic          len_err,
    output logic          err_flag
);
    import ftx_pkg::*;

    logic wr_data, wr_stat, wr_flag, rd_stat, tur_clr, wr_lock;

    assign wr_data = bus_wr && (bus_addr == REG_DATA);
    assign wr_stat = bus_wr && (bus_addr == REG_STAT);
    assign wr_flag = bus_wr && (bus_addr == REG_FLAG);
    assign rd_stat = bus_rd && (bus_addr == REG_STAT);
    assign tur_clr = wr_stat && bus_wdata[0] && tur;

    // Buffer: an accepted write wins; clearing the underrun or a load empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_valid <= 1'b0;
            buf_data  <= '0;
        end else if (wr_data && !wr_lock) begin
            buf_valid <= 1'b1;
            buf_data  <= bus_wdata;
        end else if (tur_clr || consume) begin
            buf_valid <= 1'b0;
        end
    end

    // Lockout: armed by an underrun clear, released by a status read showing it clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                 wr_lock <= 1'b0;
        else if (tur_clr)           wr_lock <= 1'b1;
        else if (rd_stat && !tur)   wr_lock <= 1'b0;
    end

    // Sticky status bits; a new event takes priority over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tur     <= 1'b0;
            len_err <= 1'b0;
        end else begin
            if (tur_evt)                        tur <= 1'b1;
            else if (wr_stat && bus_wdata[0])   tur <= 1'b0;
            if (len_evt)                        len_err <= 1'b1;
            else if (wr_stat && bus_wdata[1])   len_err <= 1'b0;
        end
    end

    // Error flag, set only while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   err_flag <= 1'b0;
        else if ((tur_evt || len_evt) && err_ie)      err_flag <= 1'b1;
        else if (wr_flag && bus_wdata[0])             err_flag <= 1'b0;
    end

    // Read mux.
    always_comb begin
        case (bus_addr)
            REG_STAT: bus_rdata = {{(DW-2){1'b0}}, len_err, tur};
            REG_FLAG: bus_rdata = {{(DW-1){1'b0}}, err_flag};
            default:  bus_rdata = '0;
        endcase
    end

    AST_TUR_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (tur_evt && err_ie) |=> (err_flag && tur)); // R4
    AST_CLEAR_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
        tur_clr |=> !buf_valid); // R6
    AST_LOCKED_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lock && wr_data) |=> $stable(buf_data)); // R7
    AST_LEN_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        len_evt |=> len_err); // R12
endmodule

// File: rtl/ftx_framer.sv
`timescale 1ns/1ps
// Frame sequencer and shifter. Loads one word at each word boundary, or
// forces zeros when the buffer is empty or a blocking underrun is pending.
// Assumes: host_mode and ign_tur are stable while a frame is in progress.
module ftx_framer #(
    parameter int FLEN        = 8,
    parameter int FRAME_WORDS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_en,
    input  logic            host_mode,
    input  logic            ign_tur,
    input  logic            fs_in,
    input  logic            buf_valid,
    input  logic [FLEN-1:0] buf_data,
    input  logic            tur,
    output logic            consume,
    output logic            tur_evt,
    output logic            len_evt,
    output logic            fs_out,
    output logic            sdo
);
    import ftx_pkg::*;

    localparam int CW  = (FLEN > 1) ? $clog2(FLEN) : 1;
    localparam int WCW = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;

    ftx_state_e      state;
    logic [CW-1:0]   bit_cnt;
    logic [WCW-1:0]  word_cnt;
    logic [FLEN-1:0] shreg;
    logic            zero_mode;

    logic last_bit, last_word, frame_end, host_go, cli_start;
    logic start, next_word, load, force_zero;

    // Frame boundary and load decisions.
    always_comb begin
        last_bit   = (bit_cnt == CW'(FLEN-1));
        last_word  = (word_cnt == WCW'(FRAME_WORDS-1));
        frame_end  = (state == ST_SHIFT) && last_bit && last_word;
        host_go    = host_mode && buf_valid && (ign_tur || !tur);
        cli_start  = !host_mode && fs_in && ((state != ST_SHIFT) || frame_end);
        start      = bit_en && ((state == ST_SYNC) || cli_start);
        next_word  = bit_en && (state == ST_SHIFT) && last_bit && !last_word;
        load       = start || next_word;
        force_zero = start ? (!host_mode && tur && !ign_tur) : zero_mode;
        consume    = load && !force_zero && buf_valid;
        tur_evt    = load && !force_zero && !buf_valid;
        len_evt    = bit_en && !host_mode && fs_in && (state == ST_SHIFT) && !frame_end;
    end

    // Sequencer and shift register, advanced once per bit strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            word_cnt  <= '0;
            shreg     <= '0;
            zero_mode <= 1'b0;
        end else if (bit_en) begin
            if (load) begin
                shreg     <= consume ? buf_data : '0;
                zero_mode <= !consume;
                bit_cnt   <= '0;
                word_cnt  <= start ? '0 : word_cnt + 1'b1;
                state     <= ST_SHIFT;
            end else begin
                case (state)
                    ST_IDLE:  if (host_go) state <= ST_SYNC;
                    ST_SHIFT: begin
                        if (frame_end) begin
                            state <= ST_IDLE;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                            shreg   <= {shreg[FLEN-2:0], 1'b0};
                        end
                    end
                    default:  state <= ST_IDLE;
                endcase
            end
        end
    end

    assign fs_out = (state == ST_SYNC);
    assign sdo    = (state == ST_SHIFT) && shreg[FLEN-1];

    AST_SYNC_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_out && bit_en) |=> !fs_out); // R2
    AST_ZERO_WHILE_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SHIFT) && zero_mode) |-> !sdo); // R3
    AST_HOST_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (host_mode && tur && !ign_tur && (state == ST_IDLE)) |=> (state != ST_SYNC)); // R5
endmodule

// File: rtl/ftx_underrun_ctrl.sv
`timescale 1ns/1ps
// Top: framed serial transmitter with underrun and frame-length error policy.
// Assumes: bus strobes are single-cycle and never both high.
module ftx_underrun_ctrl #(
    parameter int FLEN        = 8,
    parameter int FRAME_WORDS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_en,
    input  logic            host_mode,
    input  logic            ign_tur,
    input  logic            err_ie,
    input  logic            fs_in,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [1:0]      bus_addr,
    input  logic [FLEN-1:0] bus_wdata,
    output logic [FLEN-1:0] bus_rdata,
    output logic            fs_out,
    output logic            sdo,
    output logic            err_irq
);
    logic            consume, tur_evt, len_evt, buf_valid, tur, len_err;
    logic [FLEN-1:0] buf_data;

    ftx_bufregs #(.DW(FLEN)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .err_ie(err_ie), .consume(consume), .tur_evt(tur_evt), .len_evt(len_evt),
        .buf_valid(buf_valid), .buf_data(buf_data), .tur(tur),
        .len_err(len_err), .err_flag(err_irq)
    );

    ftx_framer #(.FLEN(FLEN), .FRAME_WORDS(FRAME_WORDS)) u_framer (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .host_mode(host_mode),
        .ign_tur(ign_tur), .fs_in(fs_in), .buf_valid(buf_valid),
        .buf_data(buf_data), .tur(tur), .consume(consume), .tur_evt(tur_evt),
        .len_evt(len_evt), .fs_out(fs_out), .sdo(sdo)
    );
endmodule

// File: tb/sim_ftx_underrun_ctrl.sv
`timescale 1ns/1ps
// Bench: table of host frames, then directed underrun, lockout and client cases.
module sim_ftx_underrun_ctrl;
    localparam logic [1:0] A_DATA = 2'd0, A_STAT = 2'd1, A_FLAG = 2'd2;
    // Each vector: word0 in [15:8], word1 in [7:0]; expected stream equals the vector.
    localparam logic [15:0] HOST_VEC [4] = '{16'hA53C, 16'hFF00, 16'h0181, 16'h7E96};

    logic clk = 0, rst_n = 0, bit_en = 1, host_mode = 1, ign_tur = 0, err_ie = 1;
    logic fs_in = 0, bus_wr = 0, bus_rd = 0;
    logic [1:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic fs_out, sdo, err_irq;
    int checks = 0, errors = 0;
    logic done = 0;

    ftx_underrun_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .host_mode(host_mode),
        .ign_tur(ign_tur), .err_ie(err_ie), .fs_in(fs_in), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .fs_out(fs_out), .sdo(sdo), .err_irq(err_irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 0;
    endtask

    // Collects one frame; optional data write at bit wr_at and extra sync at bit fs_at.
    task automatic frame(input bit host, input int wr_at, input logic [7:0] wv,
                         input int fs_at, output logic [15:0] s, output bit ok);
        ok = 1; s = '0;
        if (host) begin
            int n = 0;
            while (!fs_out && n < 40) begin @(negedge clk); n++; end
            if (!fs_out) begin ok = 0; return; end
        end else begin
            @(negedge clk); fs_in = 1;
        end
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (i == 0 && fs_out) ok = 0;
            bus_wr = 0; fs_in = 0;
            s[15-i] = sdo;
            if (i == wr_at) begin bus_wr = 1; bus_addr = A_DATA; bus_wdata = wv; end
            if (i == fs_at) fs_in = 1;
        end
        @(negedge clk); bus_wr = 0; fs_in = 0;
    endtask

    task automatic no_fs(input int n, input string tag);
        int seen = 0;
        for (int i = 0; i < n; i++) begin @(negedge clk); if (fs_out) seen++; end
        chk(tag, 16'(seen), 16'd0);
    endtask

    task automatic clr_all();
        logic [7:0] d;
        wr(A_STAT, 8'h03); wr(A_FLAG, 8'h01); rd(A_STAT, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] s; logic [7:0] d; bit ok;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 sdo", 16'(sdo), 0); chk("R1 fs_out", 16'(fs_out), 0);
        chk("R1 irq", 16'(err_irq), 0);
        rd(A_STAT, d); chk("R1 status", 16'(d), 0);

        // R2 host frames from the vector table
        foreach (HOST_VEC[k]) begin
            wr(A_DATA, HOST_VEC[k][15:8]);
            frame(1, 0, HOST_VEC[k][7:0], -1, s, ok);
            chk("R2 sync seen, one bit", 16'(ok), 1);
            chk("R2 stream", s, HOST_VEC[k]);
            rd(A_STAT, d); chk("R2 no underrun", 16'(d), 0);
        end

        // R3/R4 host underrun on second word
        wr(A_DATA, 8'hA5);
        frame(1, -1, 8'h00, -1, s, ok);
        chk("R3 zero tail", s, 16'hA500);
        rd(A_STAT, d); chk("R3 underrun bit", 16'(d), 16'h01);
        chk("R4 irq raised", 16'(err_irq), 1);
        // R5 blocked despite new data
        wr(A_DATA, 8'h11);
        no_fs(30, "R5 no sync while underrun");
        // R6 clear flushes the buffer
        wr(A_STAT, 8'h01);
        no_fs(20, "R6 flushed, no sync");
        // R7 locked writes dropped until status read
        wr(A_DATA, 8'h22);
        no_fs(20, "R7 locked write ignored");
        rd(A_STAT, d); chk("R7 status reads clear", 16'(d), 0);
        wr(A_DATA, 8'h33);
        frame(1, -1, 8'h00, -1, s, ok);
        chk("R7 write accepted after read", 16'(ok), 1);
        chk("R7 stream", s, 16'h3300);
        // R13 write-one-to-clear of flag
        wr(A_FLAG, 8'h01); chk("R13 flag cleared", 16'(err_irq), 0);
        clr_all();

        // R4 no flag when disabled
        err_ie = 0;
        wr(A_DATA, 8'h5C);
        frame(1, -1, 8'h00, -1, s, ok);
        rd(A_STAT, d); chk("R4 status set anyway", 16'(d), 16'h01);
        chk("R4 irq gated", 16'(err_irq), 0);
        clr_all(); err_ie = 1;

        // R11 host ignore mode: data written in underrun frame starts next frame
        ign_tur = 1;
        wr(A_DATA, 8'h3C);
        frame(1, 10, 8'h81, -1, s, ok);
        chk("R11 underrun frame", s, 16'h3C00);
        frame(1, 0, 8'h42, -1, s, ok);
        chk("R11 new sync", 16'(ok), 1);
        chk("R11 stream", s, 16'h8142);
        ign_tur = 0;
        clr_all();

        // R8 client sync with empty buffer
        host_mode = 0;
        frame(0, -1, 8'h00, -1, s, ok);
        chk("R8 zero frame", s, 16'h0000);
        rd(A_STAT, d); chk("R8 underrun bit", 16'(d), 16'h01);
        // R9 zeros while underrun pending
        wr(A_DATA, 8'h99);
        frame(0, -1, 8'h00, -1, s, ok);
        chk("R9 zeros kept", s, 16'h0000);
        // R10 ignore mode resamples buffer
        ign_tur = 1;
        frame(0, -1, 8'h00, -1, s, ok);
        chk("R10 buffered word sent", s, 16'h9900);
        ign_tur = 0;
        clr_all();

        // R12 extra sync mid frame
        wr(A_DATA, 8'hC3);
        frame(0, 0, 8'h5A, 4, s, ok);
        chk("R12 stream unchanged", s, 16'hC35A);
        rd(A_STAT, d); chk("R12 length error bit", 16'(d), 16'h02);
        chk("R12 irq", 16'(err_irq), 1);
        // R13 clear length error by writing one
        wr(A_STAT, 8'h02);
        rd(A_STAT, d); chk("R13 status cleared", 16'(d), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule